// File: doc/BRIEF.md
# Multiplexed Analog Scan Controller

This block sits between a byte-wide register bus and an analog-to-digital converter that sits behind a channel multiplexer. Software programs an inclusive window of channels with a low and a high channel register. It also chooses an input range and a settling interval, and then starts work in one of two ways: by writing to the data register, or by letting an external pacing tick trigger each start. In single mode, one start converts the low channel once. In scan mode, one start converts every channel from low to high, stepping upward and wrapping past the top channel when the high channel is below the low channel.

The converter is a stub. The block drives the channel number on `adc_chan`, waits a fixed number of cycles, and then captures the signed 16-bit word on `adc_sample`. Each captured word goes into a result FIFO. Software reads the low byte at offset 0 without side effects. It reads the high byte, with its top bit inverted so that the pair forms offset binary, at offset 1, and that read pops the entry. The bus has no back-pressure toward the converter. A capture that finds the FIFO full is dropped and sets a sticky overflow flag. When a started sequence finishes with the interrupt enabled, a pending flag is latched and drives `irq` until software clears it.

The block also reports two separate busy conditions. One covers a conversion or scan in progress. The other is a settling flag, which runs for a programmable interval after any change of channel or range.

Top module: `ascan_ctrl`

## Requirements
- R1: After `rst_n` low, or after a write with bit 5 set at offset 8, the block is idle, the FIFO is empty, the pending interrupt is cleared and every register is zero. Offset 8 then reads 0x60, offset 7 reads 0x80, and offsets 2, 3, 9 and 11 read 0x00. A soft reset aborts a scan in progress.
- R2: Offsets 2 (low channel) and 3 (high channel) keep only the low 5 bits of a write. Writing 0x80 reads back 0x00, and writing 0xFF reads back 0x1F.
- R3: Offset 11 stores write bits 6:0 and returns them in read bits 6:0. Bits 3:0 hold the range code (0x0C, 0x0D, 0x08, 0x00) and bits 5:4 the settling select. Read bit 7 is the settling flag. A write to offset 2, 3 or 11 holds it at 1 for exactly (20 − 5·sel)·CYC_PER_US cycles, where sel is the new select value for an offset-11 write and the stored value otherwise.
- R4: Offset 8 reads {busy, idle, FIFO empty, current channel[4:0]}. Busy is 1 from the cycle after an accepted start until the last capture.
- R5: With the scan-enable bit clear (offset 7 bit 2), a start converts the low channel once and pushes exactly one entry.
- R6: With scan enable set, a start converts channels low, low+1, … up to high inclusive, modulo 32, pushing ((high − low) mod 32) + 1 entries in that order.
- R7: A read of offset 0 returns the low byte of the oldest entry and does not pop it. A read of offset 1 returns the high byte with bit 7 inverted and pops the entry. Both return 0x00 when the FIFO is empty, and a read of offset 1 on an empty FIFO changes nothing.
- R8: A start (write to offset 0 or pacing tick) that arrives while busy is ignored and is not queued.
- R9: Offset 9 bits 1:0 read back as written. When they equal 3, a `pace_tick` pulse starts a sequence. Otherwise `pace_tick` has no effect.
- R10: When a sequence ends while offset 9 write bit 7 (interrupt enable) is set, a pending flag is latched. It drives `irq` and offset 9 read bit 7, and it stays set, even if the enable is later cleared, until a write with bit 3 set at offset 8. No flag is latched when the enable is clear.
- R11: Offset 7 reads {empty, full, overflow, 2'b0, scan enable, 2'b0}. A capture into a full FIFO is dropped and sets the sticky overflow bit. A write with bit 1 set at offset 7 empties the FIFO and clears overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe; pops the FIFO at offset 1 |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pace_tick | input | 1 | Pacing pulse used as a start when selected |
| adc_chan | output | CHAN_W | Channel presented to the converter |
| adc_sample | input | 16 | Signed converter result |
| irq | output | 1 | End-of-scan interrupt, level, held until cleared |

## Verification
The properties assume three things about the inputs: the bus strobes are single-cycle, `adc_sample` stays stable while a channel is being converted, and `pace_tick` is a one-cycle pulse. The bench meets these conditions. It makes each register access in its own two-cycle slot and drives `pace_tick` for exactly one cycle. It derives `adc_sample` only from `adc_chan` and a salt value, which it changes only while the block is idle. Every expected byte comes from that same formula, applied to the channel order the requirements give.

// File: rtl/ascan_pkg.sv
package ascan_pkg;
  typedef logic [15:0] sample_t;

  // register offsets
  localparam logic [3:0] A_DATA   = 4'h0;
  localparam logic [3:0] A_DATAHI = 4'h1;
  localparam logic [3:0] A_LOW    = 4'h2;
  localparam logic [3:0] A_HIGH   = 4'h3;
  localparam logic [3:0] A_FIFO   = 4'h7;
  localparam logic [3:0] A_CTRL   = 4'h8;
  localparam logic [3:0] A_INTCLK = 4'h9;
  localparam logic [3:0] A_CFG    = 4'hB;

  // bit positions
  localparam int B_FIFO_FLUSH = 1;
  localparam int B_SCAN_EN    = 2;
  localparam int B_INT_CLR    = 3;
  localparam int B_SOFT_RST   = 5;
  localparam int B_INT_EN     = 7;

  localparam logic [1:0] PACE_SEL  = 2'b11;
  localparam logic [7:0] SIGN_FLIP = 8'h80;
endpackage

// File: rtl/ascan_settle.sv
module ascan_settle #(
  parameter int CYC_PER_US = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       kick,
  input  logic [1:0] sel,
  output logic       settling
);
  localparam int MAXC = 20 * CYC_PER_US;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load;

  always_comb begin
    case (sel)
      2'd0:    load = CW'(20 * CYC_PER_US);
      2'd1:    load = CW'(15 * CYC_PER_US);
      2'd2:    load = CW'(10 * CYC_PER_US);
      default: load = CW'(5 * CYC_PER_US);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr)           cnt_q <= '0;
    else if (kick)          cnt_q <= load;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign settling = (cnt_q != '0);
endmodule

// File: rtl/ascan_seq.sv
module ascan_seq #(
  parameter int CHAN_W      = 5,
  parameter int CONV_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic              scan_en,
  input  logic [CHAN_W-1:0] lo,
  input  logic [CHAN_W-1:0] hi,
  output logic [CHAN_W-1:0] chan,
  output logic              busy,
  output logic              capture,
  output logic              done
);
  localparam int TW = $clog2(CONV_CYCLES + 1);

  logic              busy_q, scan_q;
  logic [TW-1:0]     tmr_q;
  logic [CHAN_W-1:0] chan_q, hi_q;
  logic              last;

  assign capture = busy_q && (tmr_q == TW'(1));
  assign last    = !scan_q || (chan_q == hi_q);
  assign done    = capture && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      scan_q <= 1'b0;
      tmr_q  <= '0;
      chan_q <= '0;
      hi_q   <= '0;
    end else if (clr) begin
      busy_q <= 1'b0;
      scan_q <= 1'b0;
      tmr_q  <= '0;
      chan_q <= '0;
      hi_q   <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        scan_q <= scan_en;
        tmr_q  <= TW'(CONV_CYCLES);
        chan_q <= lo;
        hi_q   <= hi;
      end
    end else if (capture) begin
      if (last) begin
        busy_q <= 1'b0;
        tmr_q  <= '0;
      end else begin
        chan_q <= chan_q + 1'b1;
        tmr_q  <= TW'(CONV_CYCLES);
      end
    end else begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  assign chan = chan_q;
  assign busy = busy_q;
endmodule

// File: rtl/ascan_fifo.sv
module ascan_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [WIDTH-1:0]           din,
  input  logic                       pop,
  output logic [WIDTH-1:0]           dout,
  output logic                       empty,
  output logic                       full,
  output logic                       overflow,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [AW:0]      cnt_q;
  logic             ovf_q;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      if (push && full) ovf_q <= 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign dout     = mem[rp_q];
  assign overflow = ovf_q;
  assign count    = cnt_q;
endmodule

// File: rtl/ascan_ctrl.sv
module ascan_ctrl
  import ascan_pkg::*;
#(
  parameter int CHAN_W      = 5,
  parameter int FIFO_DEPTH  = 32,
  parameter int CONV_CYCLES = 8,
  parameter int CYC_PER_US  = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  input  logic              pace_tick,
  output logic [CHAN_W-1:0] adc_chan,
  input  logic [15:0]       adc_sample,
  output logic              irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  logic [CHAN_W-1:0] lo_q, hi_q;
  logic [6:0]        cfg_q;
  logic              scan_en_q, ie_q, pend_q;
  logic [1:0]        clksel_q;

  logic soft_rst, int_clr, fifo_flush, start_req, settle_kick;
  logic [1:0] settle_sel;
  logic seq_busy, seq_capture, seq_done, settling;
  logic fifo_pop, fifo_empty, fifo_full, fifo_ovf;
  sample_t fifo_dout;
  logic [CNT_W-1:0] fifo_cnt;
  logic [4:0] chan5;

  // bus decode
  assign soft_rst    = reg_wr && (reg_addr == A_CTRL) && reg_wdata[B_SOFT_RST];
  assign int_clr     = reg_wr && (reg_addr == A_CTRL) && reg_wdata[B_INT_CLR];
  assign fifo_flush  = soft_rst ||
                       (reg_wr && (reg_addr == A_FIFO) && reg_wdata[B_FIFO_FLUSH]);
  assign start_req   = (reg_wr && (reg_addr == A_DATA)) ||
                       (pace_tick && (clksel_q == PACE_SEL));
  assign settle_kick = reg_wr && ((reg_addr == A_LOW) || (reg_addr == A_HIGH) ||
                                  (reg_addr == A_CFG));
  assign settle_sel  = (reg_addr == A_CFG) ? reg_wdata[5:4] : cfg_q[5:4];
  assign fifo_pop    = reg_rd && (reg_addr == A_DATAHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0; hi_q <= '0; cfg_q <= '0;
      scan_en_q <= 1'b0; ie_q <= 1'b0; clksel_q <= '0; pend_q <= 1'b0;
    end else if (soft_rst) begin
      lo_q <= '0; hi_q <= '0; cfg_q <= '0;
      scan_en_q <= 1'b0; ie_q <= 1'b0; clksel_q <= '0; pend_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_LOW:    lo_q      <= reg_wdata[CHAN_W-1:0];
          A_HIGH:   hi_q      <= reg_wdata[CHAN_W-1:0];
          A_FIFO:   scan_en_q <= reg_wdata[B_SCAN_EN];
          A_INTCLK: begin
            ie_q     <= reg_wdata[B_INT_EN];
            clksel_q <= reg_wdata[1:0];
          end
          A_CFG:    cfg_q     <= reg_wdata[6:0];
          default:  ;
        endcase
      end
      // a completing sequence wins over a simultaneous clear
      if (seq_done && ie_q) pend_q <= 1'b1;
      else if (int_clr)     pend_q <= 1'b0;
    end
  end

  ascan_settle #(.CYC_PER_US(CYC_PER_US)) u_settle (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .kick(settle_kick),
    .sel(settle_sel), .settling(settling)
  );

  ascan_seq #(.CHAN_W(CHAN_W), .CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .start(start_req),
    .scan_en(scan_en_q), .lo(lo_q), .hi(hi_q), .chan(adc_chan),
    .busy(seq_busy), .capture(seq_capture), .done(seq_done)
  );

  ascan_fifo #(.WIDTH(16), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .push(seq_capture),
    .din(adc_sample), .pop(fifo_pop), .dout(fifo_dout), .empty(fifo_empty),
    .full(fifo_full), .overflow(fifo_ovf), .count(fifo_cnt)
  );

  assign chan5 = 5'(adc_chan);

  always_comb begin
    case (reg_addr)
      A_DATA:   reg_rdata = fifo_empty ? 8'h00 : fifo_dout[7:0];
      A_DATAHI: reg_rdata = fifo_empty ? 8'h00 : (fifo_dout[15:8] ^ SIGN_FLIP);
      A_LOW:    reg_rdata = 8'(lo_q);
      A_HIGH:   reg_rdata = 8'(hi_q);
      A_FIFO:   reg_rdata = {fifo_empty, fifo_full, fifo_ovf, 2'b00, scan_en_q, 2'b00};
      A_CTRL:   reg_rdata = {seq_busy, !seq_busy, fifo_empty, chan5};
      A_INTCLK: reg_rdata = {pend_q, 5'b00000, clksel_q};
      A_CFG:    reg_rdata = {settling, cfg_q};
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign irq = pend_q;
endmodule

// File: rtl/ascan_ctrl_chk.sv
module ascan_ctrl_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       reg_addr,
  input logic [7:0]       reg_wdata,
  input logic             reg_wr,
  input logic             irq,
  input logic             seq_busy,
  input logic             seq_done,
  input logic             push,
  input logic             pop,
  input logic             flush,
  input logic             fifo_full,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             settling
);
  logic ctrl_wr, srst_w, clr_w, chg_w;
  assign ctrl_wr = reg_wr && (reg_addr == 4'h8);
  assign srst_w  = ctrl_wr && reg_wdata[5];
  assign clr_w   = ctrl_wr && (reg_wdata[3] || reg_wdata[5]);
  assign chg_w   = reg_wr && ((reg_addr == 4'h2) || (reg_addr == 4'h3) ||
                              (reg_addr == 4'hB));

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_w |=> irq);

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(seq_done));

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && fifo_full && !pop && !flush |=> $stable(fifo_cnt));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy && !seq_done && !srst_w |=> seq_busy);

  // R1
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_w |=> !seq_busy && !irq && (fifo_cnt == '0) && !settling);

  // R3
  settle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_w |=> settling);
endmodule

bind ascan_ctrl ascan_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_wr(reg_wr), .irq(irq), .seq_busy(seq_busy), .seq_done(seq_done),
  .push(seq_capture), .pop(fifo_pop), .flush(fifo_flush),
  .fifo_full(fifo_full), .fifo_cnt(fifo_cnt), .settling(settling)
);

// File: tb/ascan_ctrl_bench.sv
module ascan_ctrl_bench;
  localparam int CW   = 5;
  localparam int DEP  = 8;
  localparam int CONV = 3;
  localparam int CPU  = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [3:0]    reg_addr;
  logic [7:0]    reg_wdata;
  logic          reg_wr, reg_rd;
  logic [7:0]    reg_rdata;
  logic          pace_tick;
  logic [CW-1:0] adc_chan;
  logic [15:0]   adc_sample;
  logic          irq;
  logic [7:0]    salt;

  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [15:0] samp(input logic [4:0] c, input logic [7:0] s);
    return {8'(s + {c, 3'b000}), 8'({3'b000, c} * 8'd37 + s)};
  endfunction

  assign adc_sample = samp(adc_chan, salt);

  ascan_ctrl #(.CHAN_W(CW), .FIFO_DEPTH(DEP), .CONV_CYCLES(CONV), .CYC_PER_US(CPU)) u_ascan_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .pace_tick(pace_tick), .adc_chan(adc_chan), .adc_sample(adc_sample), .irq(irq)
  );

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] v;
    bit ok = 0;
    for (int i = 0; i < 600; i++) begin
      peek(4'h8, v);
      if (!v[7] && v[6]) begin ok = 1; break; end
      @(negedge clk);
    end
    if (!ok) check({tag, " idle timeout"}, 16'h1, 16'h0);
  endtask

  task automatic drain(input string tag, input int lo, input int n);
    logic [7:0] v0, v1;
    logic [15:0] e;
    for (int k = 0; k < n; k++) begin
      e = samp(5'((lo + k) & 31), salt);
      rd(4'h0, v0);
      check({tag, " low byte"}, {8'h00, v0}, {8'h00, e[7:0]});
      rd(4'h1, v1);
      check({tag, " high byte"}, {8'h00, v1}, {8'h00, e[15:8] ^ 8'h80});
    end
  endtask

  task automatic pulse_pace();
    @(negedge clk); pace_tick = 1'b1;
    @(negedge clk); pace_tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    report();
  end

  initial begin
    logic [7:0] v;
    int nsc, nset;
    int los [6] = '{0, 0, 5, 30, 31, 28};
    int his [6] = '{0, 7, 9, 1, 31, 3};
    rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_wr = 0; reg_rd = 0;
    pace_tick = 0; salt = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 hard reset state
    peek(4'h8, v); check("R1 status after reset", v, 8'h60);
    peek(4'h7, v); check("R1 fifo status after reset", v, 8'h80);
    peek(4'h9, v); check("R1 intclk after reset", v, 8'h00);
    check("R1 irq after reset", irq, 0);

    // R2 channel register width
    wr(4'h2, 8'h80); peek(4'h2, v); check("R2 low readback", v, 8'h00);
    wr(4'h3, 8'hFF); peek(4'h3, v); check("R2 high readback", v, 8'h1F);

    // R3 settle sweep over every select and range code
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < 4; r++) begin
        logic [7:0] code;
        code = (r == 0) ? 8'h0C : (r == 1) ? 8'h0D : (r == 2) ? 8'h08 : 8'h00;
        code = code | 8'(s << 4);
        nset = (20 - 5 * s) * CPU;
        wr(4'hB, code);
        repeat (nset - 1) @(negedge clk);
        peek(4'hB, v); check("R3 settling at last cycle", v, code | 8'h80);
        @(negedge clk);
        peek(4'hB, v); check("R3 settled readback", v, code);
      end
    end
    // R3 channel write restarts settling with stored select (3 -> 5us)
    wr(4'h2, 8'h04);
    repeat (5 * CPU - 1) @(negedge clk);
    peek(4'hB, v); check("R3 settling after channel write", v[7], 1);
    @(negedge clk);
    peek(4'hB, v); check("R3 settle ends after channel write", v[7], 0);

    // R5 R4 R7 single conversions over every channel
    wr(4'h7, 8'h00);
    for (int c = 0; c < 32; c++) begin
      salt = 8'(c * 5 + 1);
      wr(4'h2, 8'(c));
      wr(4'h3, 8'(c ^ 3));
      wr(4'h0, 8'h00);
      peek(4'h8, v); check("R4 busy status", v, 8'hA0 | 8'(c));
      wait_idle("R5");
      peek(4'h8, v); check("R4 idle status with data", v, 8'h40 | 8'(c));
      drain("R5 R7 single", c, 1);
      peek(4'h7, v); check("R5 one entry only", v, 8'h80);
    end

    // R6 scan windows including wrap
    wr(4'h7, 8'h04);
    for (int p = 0; p < 6; p++) begin
      salt = 8'(p * 29 + 7);
      nsc = ((his[p] - los[p]) & 31) + 1;
      wr(4'h2, 8'(los[p]));
      wr(4'h3, 8'(his[p]));
      wr(4'h0, 8'h00);
      wait_idle("R6");
      peek(4'h7, v); check("R6 fifo after scan", v, (nsc == DEP) ? 8'h44 : 8'h04);
      drain("R6 scan", los[p], nsc);
      peek(4'h7, v); check("R6 drained", v, 8'h84);
    end

    // R8 starts while busy are dropped
    salt = 8'h5A;
    wr(4'h2, 8'h00); wr(4'h3, 8'h03);
    wr(4'h0, 8'h00); wr(4'h0, 8'h00); wr(4'h0, 8'h00);
    wait_idle("R8");
    drain("R8 scan", 0, 4);
    peek(4'h7, v); check("R8 no extra scan", v, 8'h84);

    // R9 pacing
    wr(4'h9, 8'h00);
    pulse_pace();
    repeat (20) @(negedge clk);
    peek(4'h7, v); check("R9 tick ignored when not selected", v, 8'h84);
    wr(4'h9, 8'h03);
    peek(4'h9, v); check("R9 clock select readback", v, 8'h03);
    salt = 8'hC3;
    wr(4'h2, 8'h02); wr(4'h3, 8'h04);
    pulse_pace();
    wait_idle("R9");
    drain("R9 paced scan", 2, 3);
    peek(4'h7, v); check("R9 paced count", v, 8'h84);
    wr(4'h9, 8'h00);

    // R10 interrupt latch
    salt = 8'h11;
    wr(4'h2, 8'h00); wr(4'h3, 8'h01);
    wr(4'h0, 8'h00); wait_idle("R10");
    repeat (2) @(negedge clk);
    check("R10 no irq when disabled", irq, 0);
    drain("R10 scan a", 0, 2);
    wr(4'h9, 8'h80);
    peek(4'h9, v); check("R10 not pending before scan", v, 8'h00);
    wr(4'h0, 8'h00); wait_idle("R10");
    check("R10 irq after scan", irq, 1);
    peek(4'h9, v); check("R10 pending readback", v, 8'h80);
    repeat (10) @(negedge clk);
    check("R10 irq held", irq, 1);
    wr(4'h9, 8'h00);
    check("R10 irq held after disable", irq, 1);
    wr(4'h8, 8'h08);
    check("R10 irq cleared", irq, 0);
    peek(4'h9, v); check("R10 pending cleared", v, 8'h00);
    drain("R10 scan b", 0, 2);

    // R11 overflow, full, flush
    salt = 8'h77;
    wr(4'h2, 8'h00); wr(4'h3, 8'h1F);
    wr(4'h0, 8'h00); wait_idle("R11");
    peek(4'h7, v); check("R11 full and overflow", v, 8'h64);
    drain("R11 first entries kept", 0, DEP);
    peek(4'h7, v); check("R11 overflow sticky", v, 8'hA4);
    rd(4'h1, v); check("R7 empty high read", v, 8'h00);
    peek(4'h7, v); check("R7 empty pop no effect", v, 8'hA4);
    wr(4'h7, 8'h06);
    peek(4'h7, v); check("R11 flush clears overflow", v, 8'h84);
    wr(4'h3, 8'h02);
    wr(4'h0, 8'h00); wait_idle("R11");
    peek(4'h7, v); check("R11 entries before flush", v, 8'h04);
    wr(4'h7, 8'h06);
    peek(4'h7, v); check("R11 flush empties", v, 8'h84);
    rd(4'h0, v); check("R7 empty low read", v, 8'h00);

    // R1 soft reset aborts a scan
    wr(4'h9, 8'h83); wr(4'hB, 8'h1C);
    wr(4'h2, 8'h03); wr(4'h3, 8'h14);
    wr(4'h0, 8'h00);
    repeat (4) @(negedge clk);
    wr(4'h8, 8'h20);
    peek(4'h8, v); check("R1 soft reset status", v, 8'h60);
    peek(4'h7, v); check("R1 soft reset fifo", v, 8'h80);
    peek(4'h2, v); check("R1 soft reset low", v, 8'h00);
    peek(4'h3, v); check("R1 soft reset high", v, 8'h00);
    peek(4'h9, v); check("R1 soft reset intclk", v, 8'h00);
    peek(4'hB, v); check("R1 soft reset config", v, 8'h00);
    check("R1 soft reset irq", irq, 0);
    repeat (50) @(negedge clk);
    peek(4'h7, v); check("R1 scan aborted", v, 8'h80);
    wr(4'hB, 8'h0C);
    repeat (20 * CPU + 1) @(negedge clk);
    peek(4'hB, v); check("R3 unipolar code readback", v, 8'h0C);

    report();
  end
endmodule